// File: doc/BRIEF.md
# Digit-Serial Montgomery Modular Multiplier (17-bit digits)

This block computes S = X·Y·2^(-17d) mod M for operands made of d digits of 17 bits each. It reads the operands X, Y and M one digit at a time from digit memories attached to it with combinational read. It also reads and rewrites the running sum S in a result digit memory. The constant Minv = -M^(-1) mod 2^17 and the digit count d are given at start. A pulse on `start` launches the operation, and a one-cycle `done` pulse reports that the result memory holds S.

Each of the d rows begins with one cycle that forms the row's quotient digit q from the lowest digits. Then d+1 cycles follow, each handling one digit position j = 0..d. Two 17x17 multiply-accumulates and two 1-bit-carry additions combine the digit products with the old sum. The carry of every stage is registered separately, so no carry ripples across the word. The new sum digit is written one address below the one read, which divides the row value by 2^17 in place.

Operands must obey 17d ≥ R+3, with M odd and M < 2^(17d-3). Under that condition the result stays below 2M, so no final subtraction stage is needed.

Top module: `mont17_mul`

## Requirements
- R1: During and right after synchronous active-low reset, `busy`, `done` and `s_we` are all 0.
- R2: Suppose `start` is sampled high while idle with 1 ≤ `num_digits` ≤ MAX_DIGITS. Then `busy` is high for exactly d·(d+2) cycles, and `done` is high in the first cycle after that.
- R3: The quotient digit of row i is q = ((X0·Yi + S0)·Minv) mod 2^17, so the lowest digit of each row sum is zero and is never written. Each row writes exactly d digits, to addresses 0 up to d-1 in ascending order, one per cycle.
- R4: Every digit written in row i equals the matching digit of the exact value (S_i + X·Y_i + q·M) / 2^17, with S_0 = 0.
- R5: With X, Y < M, M odd and M < 2^(17d-3), the final S satisfies S·2^(17d) ≡ X·Y (mod M) and S < 2M. No carry remains above digit d-1 at the end of any row.
- R6: During row 0 the old contents of the result memory have no effect; the sum is taken as zero.
- R7: At digit position d, the contents of the X, M and S memories at address d have no effect; those digits are taken as zero.
- R8: `start` is ignored while busy, and `num_digits` is only sampled at an accepted start. A start with `num_digits` of 0 or above MAX_DIGITS is ignored.
- R9: `done` lasts exactly one cycle, and `s_we` is never high while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Launch request, sampled while idle |
| num_digits | input | CW | Digit count d |
| minv | input | DIGIT_W | -M^(-1) mod 2^17 |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| x_addr | output | CW | X digit address |
| x_digit | input | DIGIT_W | X digit at x_addr |
| y_addr | output | CW | Y digit address (row index) |
| y_digit | input | DIGIT_W | Y digit at y_addr |
| m_addr | output | CW | M digit address |
| m_digit | input | DIGIT_W | M digit at m_addr |
| s_raddr | output | CW | Result memory read address |
| s_rdata | input | DIGIT_W | Result memory read data |
| s_we | output | 1 | Result memory write enable |
| s_waddr | output | CW | Result memory write address |
| s_wdata | output | DIGIT_W | Result memory write data |

## Verification
The bench fills the result memory, and address d of every operand memory, with random junk before each run. A design that failed to mask the stale sum in row 0, or the extra digit at j = d, would then write digits that differ from the row-by-row reference. The runs cover d = 1, where the quotient cycle and the single digit write sit back to back, and d = MAX_DIGITS, where the carry chains are longest. A quotient digit formed from the wrong inputs leaves a nonzero lowest digit, which shifts every later row and breaks the final congruence. A mid-run start with a different digit count, and starts with a digit count of 0 or too large, check that the captured length cannot be disturbed. If it were, the write stream, the latency or the busy flag would differ.

// File: rtl/mont17_pkg.sv
// Shared types for the digit-serial Montgomery multiplier.
package mont17_pkg;
    // Controller phases: idle, per-row quotient cycle, digit loop.
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_QUOT = 2'd1,
        PH_LOOP = 2'd2
    } mont_phase_t;
endpackage

// File: rtl/mont17_qgen.sv
// Quotient digit generator.
// Computes q = ((x0*yi + s0) * minv) mod 2^W, purely combinational.
// Assumes s0 is already forced to zero by the caller in row 0.
module mont17_qgen #(
    parameter int DIGIT_W = 17
) (
    input  logic [DIGIT_W-1:0] x0,
    input  logic [DIGIT_W-1:0] yi,
    input  logic [DIGIT_W-1:0] s0,
    input  logic [DIGIT_W-1:0] minv,
    output logic [DIGIT_W-1:0] q
);
    localparam int PW = 2 * DIGIT_W;

    logic [PW-1:0] xy_low;
    logic [PW-1:0] q_full;
    logic [DIGIT_W-1:0] t_low;

    // Only the low digit of x0*yi + s0 feeds the quotient.
    always_comb begin
        xy_low = {{DIGIT_W{1'b0}}, x0} * {{DIGIT_W{1'b0}}, yi};
        t_low  = xy_low[DIGIT_W-1:0] + s0;
        q_full = {{DIGIT_W{1'b0}}, t_low} * {{DIGIT_W{1'b0}}, minv};
        q      = q_full[DIGIT_W-1:0];
    end
endmodule

// File: rtl/mont17_digit_pe.sv
// Digit processing element holding the four row carries.
// Per step: {ca,a} = xj*yi + ca ; {cb,b} = q*mj + cb ;
//           {cg,g} = a + b + cg ; {cs,sum} = g + sj + cs.
// Assumes callers zero xj, mj, sj where the algorithm needs zero.
module mont17_digit_pe #(
    parameter int DIGIT_W = 17
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               en,
    input  logic               first,
    input  logic               last,
    input  logic [DIGIT_W-1:0] xj,
    input  logic [DIGIT_W-1:0] yi,
    input  logic [DIGIT_W-1:0] qd,
    input  logic [DIGIT_W-1:0] mj,
    input  logic [DIGIT_W-1:0] sj,
    output logic [DIGIT_W-1:0] sum_digit
);
    localparam int PW = 2 * DIGIT_W;

    logic [DIGIT_W-1:0] ca, cb;
    logic               cg, cs;
    logic [PW-1:0]      pa, pb;
    logic [DIGIT_W:0]   g, s;

    // Combinational digit arithmetic with split carries.
    always_comb begin
        pa = {{DIGIT_W{1'b0}}, xj} * {{DIGIT_W{1'b0}}, yi} + {{DIGIT_W{1'b0}}, ca};
        pb = {{DIGIT_W{1'b0}}, qd} * {{DIGIT_W{1'b0}}, mj} + {{DIGIT_W{1'b0}}, cb};
        g  = {1'b0, pa[DIGIT_W-1:0]} + {1'b0, pb[DIGIT_W-1:0]} + {{DIGIT_W{1'b0}}, cg};
        s  = {1'b0, g[DIGIT_W-1:0]} + {1'b0, sj} + {{DIGIT_W{1'b0}}, cs};
        sum_digit = s[DIGIT_W-1:0];
    end

    // Carry registers: cleared per row, advanced per digit step.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            ca <= '0;
            cb <= '0;
            cg <= 1'b0;
            cs <= 1'b0;
        end else if (en) begin
            ca <= pa[PW-1:DIGIT_W];
            cb <= pb[PW-1:DIGIT_W];
            cg <= g[DIGIT_W];
            cs <= s[DIGIT_W];
        end
    end

    AST_LOW_DIGIT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (en && first) |-> (sum_digit == '0)); // R3
    AST_ROW_SPILL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (en && last) |-> (!g[DIGIT_W] && !s[DIGIT_W] && pa[PW-1:DIGIT_W] == '0)); // R5
endmodule

// File: rtl/mont17_seq.sv
// Row/digit sequencer.
// Captures the digit count at an accepted start, then runs d rows of
// one quotient cycle plus d+1 digit cycles, then pulses done.
// Assumes 1 <= num_digits <= MAX_DIGITS for a start to be accepted.
module mont17_seq
    import mont17_pkg::*;
#(
    parameter int MAX_DIGITS = 8,
    parameter int CW = $clog2(MAX_DIGITS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [CW-1:0] num_digits,
    output logic          busy,
    output logic          done,
    output logic          in_quot,
    output logic          in_loop,
    output logic          first_step,
    output logic          last_step,
    output logic          row0,
    output logic [CW-1:0] row_idx,
    output logic [CW-1:0] dig_idx,
    output logic [CW-1:0] d_cur
);
    mont_phase_t   phase;
    logic [CW-1:0] i_q, j_q, d_q;
    logic          done_q;
    logic          len_ok;

    // Accepted digit counts.
    assign len_ok = (num_digits != '0) && (num_digits <= CW'(MAX_DIGITS));

    // Phase, counters and completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase  <= PH_IDLE;
            i_q    <= '0;
            j_q    <= '0;
            d_q    <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (phase)
                PH_IDLE: begin
                    if (start && len_ok) begin
                        d_q   <= num_digits;
                        i_q   <= '0;
                        j_q   <= '0;
                        phase <= PH_QUOT;
                    end
                end
                PH_QUOT: begin
                    j_q   <= '0;
                    phase <= PH_LOOP;
                end
                PH_LOOP: begin
                    if (j_q == d_q) begin
                        if (i_q == d_q - CW'(1)) begin
                            phase  <= PH_IDLE;
                            done_q <= 1'b1;
                        end else begin
                            i_q   <= i_q + CW'(1);
                            phase <= PH_QUOT;
                        end
                    end else begin
                        j_q <= j_q + CW'(1);
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    // Decoded status toward the datapath.
    always_comb begin
        busy       = (phase != PH_IDLE);
        done       = done_q;
        in_quot    = (phase == PH_QUOT);
        in_loop    = (phase == PH_LOOP);
        first_step = in_loop && (j_q == '0);
        last_step  = in_loop && (j_q == d_q);
        row0       = (i_q == '0);
        row_idx    = i_q;
        dig_idx    = j_q;
        d_cur      = d_q;
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R9
    AST_LEN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(d_q)); // R8
    AST_DIGIT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        in_loop |-> (j_q <= d_q && i_q < d_q)); // R2
endmodule

// File: rtl/mont17_mul.sv
// Digit-serial Montgomery multiplier top.
// Drives the operand and result memory addresses, masks the zero digits
// (row-0 sum and position d), forms q in the quotient cycle and writes
// each new sum digit one address below the digit read.
// Assumes combinational-read digit memories and 17d >= R+3.
module mont17_mul #(
    parameter int DIGIT_W    = 17,
    parameter int MAX_DIGITS = 8,
    localparam int CW        = $clog2(MAX_DIGITS + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [CW-1:0]      num_digits,
    input  logic [DIGIT_W-1:0] minv,
    output logic               busy,
    output logic               done,
    output logic [CW-1:0]      x_addr,
    input  logic [DIGIT_W-1:0] x_digit,
    output logic [CW-1:0]      y_addr,
    input  logic [DIGIT_W-1:0] y_digit,
    output logic [CW-1:0]      m_addr,
    input  logic [DIGIT_W-1:0] m_digit,
    output logic [CW-1:0]      s_raddr,
    input  logic [DIGIT_W-1:0] s_rdata,
    output logic               s_we,
    output logic [CW-1:0]      s_waddr,
    output logic [DIGIT_W-1:0] s_wdata
);
    logic               in_quot, in_loop, first_step, last_step, row0;
    logic [CW-1:0]      row_idx, dig_idx, d_cur;
    logic [DIGIT_W-1:0] q_new, q_r, yi_r, s0_eff;
    logic [DIGIT_W-1:0] xj_eff, mj_eff, sj_eff, sum_digit;

    mont17_seq #(.MAX_DIGITS(MAX_DIGITS), .CW(CW)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .num_digits (num_digits),
        .busy       (busy),
        .done       (done),
        .in_quot    (in_quot),
        .in_loop    (in_loop),
        .first_step (first_step),
        .last_step  (last_step),
        .row0       (row0),
        .row_idx    (row_idx),
        .dig_idx    (dig_idx),
        .d_cur      (d_cur)
    );

    // Address generation: digit 0 in the quotient cycle, digit j in the loop.
    always_comb begin
        x_addr  = in_quot ? '0 : dig_idx;
        m_addr  = dig_idx;
        s_raddr = in_quot ? '0 : dig_idx;
        y_addr  = row_idx;
    end

    // Zero masking of the stale row-0 sum and the position-d digits.
    always_comb begin
        s0_eff = row0 ? '0 : s_rdata;
        xj_eff = last_step ? '0 : x_digit;
        mj_eff = last_step ? '0 : m_digit;
        sj_eff = (row0 || last_step) ? '0 : s_rdata;
    end

    mont17_qgen #(.DIGIT_W(DIGIT_W)) u_qgen (
        .x0   (x_digit),
        .yi   (y_digit),
        .s0   (s0_eff),
        .minv (minv),
        .q    (q_new)
    );

    // Hold the row's quotient and multiplier digit for the digit loop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_r  <= '0;
            yi_r <= '0;
        end else if (in_quot) begin
            q_r  <= q_new;
            yi_r <= y_digit;
        end
    end

    mont17_digit_pe #(.DIGIT_W(DIGIT_W)) u_pe (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (in_quot),
        .en        (in_loop),
        .first     (first_step),
        .last      (last_step),
        .xj        (xj_eff),
        .yi        (yi_r),
        .qd        (q_r),
        .mj        (mj_eff),
        .sj        (sj_eff),
        .sum_digit (sum_digit)
    );

    // Shifted write-back: digit j of the new sum lands at address j-1.
    always_comb begin
        s_we    = in_loop && !first_step;
        s_waddr = dig_idx - CW'(1);
        s_wdata = sum_digit;
    end

    AST_NO_IDLE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !s_we); // R9
    AST_WRITE_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
        (s_we && s_waddr != d_cur - CW'(1)) |=> (s_we && s_waddr == $past(s_waddr) + CW'(1))); // R3
    AST_WRITE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        s_we |-> (s_waddr < d_cur)); // R3
endmodule

// File: tb/mont17_mul_tb.sv
`timescale 1ns/1ps
module mont17_mul_tb;
    localparam int W    = 17;
    localparam int MAXD = 8;
    localparam int CW   = $clog2(MAXD + 1);
    localparam int NA   = 2 ** CW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [CW-1:0] num_digits = '0;
    logic [W-1:0]  minv = '0;
    logic          busy, done, s_we;
    logic [CW-1:0] x_addr, y_addr, m_addr, s_raddr, s_waddr;
    logic [W-1:0]  x_digit, y_digit, m_digit, s_rdata, s_wdata;

    logic [W-1:0] xmem [0:NA-1];
    logic [W-1:0] ymem [0:NA-1];
    logic [W-1:0] mmem [0:NA-1];
    logic [W-1:0] smem [0:NA-1];

    int n_cmp = 0;
    int n_bad = 0;
    longint cyc = 0;
    int unsigned exp_addr [$];
    int unsigned exp_data [$];

    always #4 clk = ~clk;

    assign x_digit = xmem[x_addr];
    assign y_digit = ymem[y_addr];
    assign m_digit = mmem[m_addr];
    assign s_rdata = smem[s_raddr];

    always @(posedge clk) if (s_we) smem[s_waddr] <= s_wdata;

    mont17_mul #(.DIGIT_W(W), .MAX_DIGITS(MAXD)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .num_digits(num_digits),
        .minv(minv), .busy(busy), .done(done),
        .x_addr(x_addr), .x_digit(x_digit), .y_addr(y_addr), .y_digit(y_digit),
        .m_addr(m_addr), .m_digit(m_digit), .s_raddr(s_raddr), .s_rdata(s_rdata),
        .s_we(s_we), .s_waddr(s_waddr), .s_wdata(s_wdata)
    );

    task automatic chk(input bit ok, input string req,
                       input logic [319:0] act, input logic [319:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Watchdog: a hung run counts as one failure and still reports.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=<150000", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    // Per-clock comparison of the write stream against the reference queue.
    always @(negedge clk) begin
        if (rst_n) begin
            if (s_we) begin
                if (exp_addr.size() == 0) begin
                    chk(1'b0, "R9 unexpected write", 320'(s_waddr), 0);
                end else begin
                    int unsigned ea, ed;
                    ea = exp_addr.pop_front();
                    ed = exp_data.pop_front();
                    chk(32'(s_waddr) == ea, "R3 write address", 320'(s_waddr), 320'(ea));
                    chk(32'(s_wdata) == ed, "R4 write digit", 320'(s_wdata), 320'(ed));
                end
            end
            if (!busy) chk(!s_we, "R9 no write while idle", 320'(s_we), 0);
        end
    end

    function automatic logic [319:0] rand_wide();
        logic [319:0] r;
        for (int k = 0; k < 10; k++) r[k*32 +: 32] = $urandom;
        return r;
    endfunction

    // One full multiplication with reference model; poke = mid-run start.
    task automatic run_case(input int d, input bit poke);
        logic [319:0] mask, xw, yw, mw, sw, t, sres, lhs, rhs;
        longint unsigned inv, m0, qv, t0;
        int nb, cnt;
        nb   = 17 * d - 3;
        mask = (320'(1) << nb) - 320'(1);
        mw   = rand_wide() & mask;
        mw[0] = 1'b1;
        mw[nb-1] = 1'b1;
        xw = rand_wide() % mw;
        yw = rand_wide() % mw;
        for (int k = 0; k < NA; k++) begin
            xmem[k] = (k < d) ? xw[k*17 +: 17] : W'($urandom);
            ymem[k] = (k < d) ? yw[k*17 +: 17] : W'($urandom);
            mmem[k] = (k < d) ? mw[k*17 +: 17] : W'($urandom);
            smem[k] = W'($urandom);
        end
        m0  = 64'(mw[16:0]);
        inv = m0;
        for (int k = 0; k < 5; k++) inv = (inv * (64'd2 - m0 * inv)) & 64'h1ffff;
        minv = W'((64'h20000 - inv) & 64'h1ffff);
        // Reference rows from the whole-number recurrence.
        sw = '0;
        for (int i = 0; i < d; i++) begin
            t0 = (64'(xmem[0]) * 64'(ymem[i]) + 64'(sw[16:0])) & 64'h1ffff;
            qv = (t0 * 64'(minv)) & 64'h1ffff;
            t  = sw + xw * 320'(ymem[i]) + 320'(qv) * mw;
            chk(t[16:0] == 17'd0, "R3 reference low digit", 320'(t[16:0]), 0);
            sw = t >> 17;
            for (int k = 0; k < d; k++) begin
                exp_addr.push_back(k);
                exp_data.push_back(32'(sw[k*17 +: 17]));
            end
        end
        @(negedge clk);
        num_digits = CW'(d);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cnt = 0;
        while (busy) begin
            cnt++;
            if (poke && cnt == 3) begin
                start = 1'b1;
                num_digits = CW'((d % MAXD) + 1);
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
        end
        start = 1'b0;
        chk(cnt == d * (d + 2), poke ? "R8 latency with mid-run start" : "R2 latency",
            320'(cnt), 320'(d * (d + 2)));
        chk(done == 1'b1, "R2 done after busy", 320'(done), 1);
        chk(exp_addr.size() == 0, "R3 all row digits written", 320'(exp_addr.size()), 0);
        sres = '0;
        for (int k = 0; k < d; k++) sres[k*17 +: 17] = smem[k];
        chk(sres == sw, "R6 R7 junk in stale sum and digit d ignored", sres, sw);
        lhs = (sres << (17 * d)) % mw;
        rhs = (xw * yw) % mw;
        chk(lhs == rhs, "R5 Montgomery congruence", lhs, rhs);
        chk(sres < (mw << 1), "R5 result below 2M", sres, mw << 1);
        @(negedge clk);
        chk(done == 1'b0, "R9 done is one cycle", 320'(done), 0);
        exp_addr.delete();
        exp_data.delete();
    endtask

    initial begin
        for (int k = 0; k < NA; k++) begin
            xmem[k] = '0; ymem[k] = '0; mmem[k] = '0; smem[k] = '0;
        end
        repeat (3) @(negedge clk);
        chk(!busy && !done && !s_we, "R1 state in reset", {busy, done, s_we}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && !s_we, "R1 state after reset", {busy, done, s_we}, 0);

        // Rejected lengths leave the block idle.
        num_digits = '0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        chk(!busy, "R8 zero length ignored", 320'(busy), 0);
        num_digits = CW'(MAXD + 1);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        chk(!busy, "R8 oversize length ignored", 320'(busy), 0);

        run_case(1, 1'b0);
        run_case(1, 1'b0);
        run_case(2, 1'b0);
        run_case(3, 1'b0);
        run_case(3, 1'b1);
        run_case(5, 1'b0);
        run_case(MAXD, 1'b0);
        run_case(MAXD, 1'b1);
        for (int r = 0; r < 6; r++) run_case((r % MAXD) + 2, 1'b0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule